// File: doc/BRIEF.md
# Complement-Balanced Encoded XOR

This block computes the exclusive-OR of two small data values that travel in complement-balanced form. Each data bit is stored next to its own inverse, so every well-formed word holds the same number of ones whatever the data. The result comes back in the same form. The operation never decodes to plain data. Instead, each operand is split into an upper and a lower half. Each half is masked out and then copied into both halves of a scratch word. The two scratch words are XORed with a fixed correction constant, and the upper half of one path is merged with the lower half of the other.

An XOR of two complement pairs always gives a pair of equal bits. The correction constant turns that equal pair back into a complementary pair. Because that step is fixed, a malformed operand is not rejected. It flows through and may come out looking well formed. For that reason the block also reports, next to each result, whether every bit pair of the result is complementary.

Operands enter through a valid/ready handshake. Results leave through a one-entry output register with its own valid/ready handshake. A new operand pair is accepted only when the output register is empty or is being drained in the same cycle. A result is held unchanged until the consumer accepts it. While the output is stalled, `in_ready` stays low. The parameter `DATA_BITS` must be even, so that each half of a word holds whole bit pairs.

Top module: `cbal_xor`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `out_valid` is 0 and `in_ready` is 1.
- R2: Data bit i of a word sits at position 2i+1 and its inverse at position 2i. For example, data value 1 encodes as 8'h56 and data value 0 encodes as 8'h55.
- R3: When both operands are well formed, the result is the well-formed encoding of the XOR of the two data values.
- R4: For any pair of operand bytes, the result equals op_a ^ op_b ^ P. P is the constant whose even-position bits are 1 and odd-position bits are 0 (8'h55 for the default width). This follows from the two-path split with the correction constants 8'h5A and 8'hA5 and the final merge.
- R5: When one operand is all zeros and the other is a well-formed word for data d, every result pair is (d_i, d_i). The data leaks in duplicated form.
- R6: `out_ok` is 1 exactly when every bit pair of `out_word` holds two different values.
- R7: An operand pair is accepted at a rising edge where `in_valid` and `in_ready` are both 1. Its result appears with `out_valid` = 1 after that edge.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_word` and `out_ok` hold their values.
- R9: With `out_ready` held at 1, `in_ready` stays 1 and one result is delivered per cycle for operands presented back to back.
- R10: Operand values presented while they are not accepted, whether because `in_valid` is 0 or because the output is stalled, leave `out_word` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block can take an operand pair |
| op_a | input | 2*DATA_BITS | First encoded operand |
| op_b | input | 2*DATA_BITS | Second encoded operand |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 2*DATA_BITS | Encoded XOR result |
| out_ok | output | 1 | Every bit pair of `out_word` is complementary |

## Verification
Every result, together with its `out_ok` flag, is due exactly one rising edge after the edge that accepts the operands. The bench drives inputs on the falling edge and samples on the following falling edge, so one register sits between stimulus and check. Under stall, the held word is re-checked one and two cycles after the ignored operands. The replacement result is checked one cycle after `out_ready` rises.

// File: rtl/cbal_xor_pkg.sv
package cbal_xor_pkg;

  // Alternating pair pattern for a word of word_bits bits.
  // odd_one = 0 gives 01 in each pair (even position set), 1 gives 10.
  function automatic logic [63:0] pair_pattern(int word_bits, bit odd_one);
    logic [63:0] p;
    p = '0;
    for (int j = 0; j < word_bits; j++)
      p[j] = odd_one ? (j % 2 == 1) : (j % 2 == 0);
    return p;
  endfunction

  // Correction constant of one path. The upper half uses one pattern and
  // the lower half the other, swapped between the two paths.
  function automatic logic [63:0] path_const(int word_bits, bit upper_path);
    logic [63:0] c;
    logic [63:0] up;
    logic [63:0] lo;
    c  = '0;
    up = pair_pattern(word_bits, !upper_path);
    lo = pair_pattern(word_bits, upper_path);
    for (int j = 0; j < word_bits; j++)
      c[j] = (j >= word_bits / 2) ? up[j] : lo[j];
    return c;
  endfunction

  function automatic logic [63:0] half_mask(int word_bits, bit upper);
    logic [63:0] m;
    m = '0;
    for (int j = 0; j < word_bits; j++)
      m[j] = upper ? (j >= word_bits / 2) : (j < word_bits / 2);
    return m;
  endfunction

endpackage

// File: rtl/cbal_xor_dup_path.sv
module cbal_xor_dup_path #(
  parameter int WORD  = 8,
  parameter bit UPPER = 1'b1
) (
  input  logic [WORD-1:0] op_a,
  input  logic [WORD-1:0] op_b,
  output logic [WORD-1:0] mid
);
  import cbal_xor_pkg::*;

  localparam int HALF = WORD / 2;
  localparam logic [63:0] MASK64 = half_mask(WORD, UPPER);
  localparam logic [63:0] CORR64 = path_const(WORD, UPPER);
  localparam logic [WORD-1:0] MASK = MASK64[WORD-1:0];
  localparam logic [WORD-1:0] CORR = CORR64[WORD-1:0];

  logic [WORD-1:0] iso_a, iso_b, dup_a, dup_b;

  assign iso_a = op_a & MASK;
  assign iso_b = op_b & MASK;

  // Half swap followed by OR places the isolated half in both halves.
  generate
    if (UPPER) begin : g_up
      assign dup_a = iso_a | {{HALF{1'b0}}, iso_a[WORD-1:HALF]};
      assign dup_b = iso_b | {{HALF{1'b0}}, iso_b[WORD-1:HALF]};
    end else begin : g_lo
      assign dup_a = iso_a | {iso_a[HALF-1:0], {HALF{1'b0}}};
      assign dup_b = iso_b | {iso_b[HALF-1:0], {HALF{1'b0}}};
    end
  endgenerate

  assign mid = (dup_a ^ CORR) ^ dup_b;

endmodule

// File: rtl/cbal_xor_pair_check.sv
module cbal_xor_pair_check #(
  parameter int WORD = 8
) (
  input  logic [WORD-1:0] word,
  output logic            all_ok
);
  localparam int PAIRS = WORD / 2;

  logic [PAIRS-1:0] pair_ok;

  generate
    for (genvar i = 0; i < PAIRS; i++) begin : g_pair
      assign pair_ok[i] = word[2*i+1] ^ word[2*i];
    end
  endgenerate

  assign all_ok = &pair_ok;

endmodule

// File: rtl/cbal_xor_out_stage.sv
module cbal_xor_out_stage #(
  parameter int WORD = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [WORD-1:0] next_word,
  input  logic            next_ok,
  input  logic            drain,
  output logic            held,
  output logic [WORD-1:0] word_q,
  output logic            ok_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= 1'b0;
      word_q <= '0;
      ok_q   <= 1'b0;
    end else begin
      if (take) begin
        held   <= 1'b1;
        word_q <= next_word;
        ok_q   <= next_ok;
      end else if (drain) begin
        held <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cbal_xor.sv
module cbal_xor #(
  parameter  int DATA_BITS = 4,
  localparam int WORD      = 2 * DATA_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [WORD-1:0] op_a,
  input  logic [WORD-1:0] op_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [WORD-1:0] out_word,
  output logic            out_ok
);
  import cbal_xor_pkg::*;

  localparam logic [63:0] UP64 = half_mask(WORD, 1'b1);
  localparam logic [63:0] LO64 = half_mask(WORD, 1'b0);
  localparam logic [WORD-1:0] UP_MASK = UP64[WORD-1:0];
  localparam logic [WORD-1:0] LO_MASK = LO64[WORD-1:0];

  logic [WORD-1:0] up_mid, lo_mid, merged;
  logic            merged_ok;
  logic            accept;

  cbal_xor_dup_path #(.WORD(WORD), .UPPER(1'b1)) u_up (
    .op_a(op_a), .op_b(op_b), .mid(up_mid)
  );

  cbal_xor_dup_path #(.WORD(WORD), .UPPER(1'b0)) u_lo (
    .op_a(op_a), .op_b(op_b), .mid(lo_mid)
  );

  assign merged = (up_mid & UP_MASK) | (lo_mid & LO_MASK);

  cbal_xor_pair_check #(.WORD(WORD)) u_chk_pairs (
    .word(merged), .all_ok(merged_ok)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  cbal_xor_out_stage #(.WORD(WORD)) u_out (
    .clk(clk), .rst_n(rst_n),
    .take(accept), .next_word(merged), .next_ok(merged_ok),
    .drain(out_ready),
    .held(out_valid), .word_q(out_word), .ok_q(out_ok)
  );

endmodule

// File: rtl/cbal_xor_chk.sv
module cbal_xor_chk #(
  parameter int WORD = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [WORD-1:0] op_a,
  input logic [WORD-1:0] op_b,
  input logic            out_valid,
  input logic            out_ready,
  input logic [WORD-1:0] out_word,
  input logic            out_ok
);
  logic [WORD-1:0]   alt;
  logic [WORD/2-1:0] pdiff;

  generate
    for (genvar j = 0; j < WORD; j++) begin : g_alt
      assign alt[j] = (j % 2 == 0);
    end
    for (genvar i = 0; i < WORD / 2; i++) begin : g_pd
      assign pdiff[i] = out_word[2*i+1] != out_word[2*i];
    end
  endgenerate

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R7
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R4
  xor_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_word == ($past(op_a) ^ $past(op_b) ^ alt));

  // R6
  flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_ok == (&pdiff));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_ok));

  // R8
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R10
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !in_valid |=> !out_valid);

endmodule

bind cbal_xor cbal_xor_chk #(.WORD(WORD)) u_cbal_xor_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_ready(out_ready),
  .out_word(out_word), .out_ok(out_ok)
);

// File: tb/sim_cbal_xor.sv
`timescale 1ns/1ps
module sim_cbal_xor;
  localparam int DB = 4;
  localparam int W  = 2 * DB;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_word;
  logic         out_ok;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cbal_xor #(.DATA_BITS(DB)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_ok(out_ok)
  );

  function automatic logic [W-1:0] enc(logic [DB-1:0] d);
    logic [W-1:0] w;
    for (int i = 0; i < DB; i++) begin
      w[2*i+1] = d[i];
      w[2*i]   = ~d[i];
    end
    return w;
  endfunction

  function automatic logic pairs_ok(logic [W-1:0] w);
    logic r;
    r = 1'b1;
    for (int i = 0; i < DB; i++)
      if (w[2*i+1] == w[2*i]) r = 1'b0;
    return r;
  endfunction

  task automatic check(input logic cond, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b);
    op_a = a;
    op_b = b;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1 out_valid", W'(out_valid), '0);
    check(in_ready == 1'b1, "R1 in_ready", W'(in_ready), W'(1));
  endtask

  task automatic t_layout();
    drive(enc(4'd1), enc(4'd0));
    in_valid = 1'b0;
    check(out_word == 8'h56, "R2 layout", out_word, 8'h56);
    check(out_valid == 1'b1, "R7 valid", W'(out_valid), W'(1));
    @(negedge clk);
  endtask

  task automatic t_valid_pairs();
    for (int da = 0; da < 16; da++) begin
      logic [DB-1:0] db;
      db = DB'((da * 7 + 3) & 15);
      drive(enc(DB'(da)), enc(db));
      in_valid = 1'b0;
      check(out_word == enc(DB'(da) ^ db), "R3 encoded xor", out_word, enc(DB'(da) ^ db));
      check(out_ok == 1'b1, "R6 ok on valid", W'(out_ok), W'(1));
      @(negedge clk);
    end
  endtask

  task automatic t_raw();
    logic [W-1:0] av [4] = '{8'h00, 8'hFF, 8'h3C, 8'h96};
    logic [W-1:0] bv [4] = '{8'hFF, 8'hFF, 8'h0F, 8'h5A};
    for (int k = 0; k < 4; k++) begin
      drive(av[k], bv[k]);
      in_valid = 1'b0;
      check(out_word == (av[k] ^ bv[k] ^ 8'h55), "R4 raw bytes", out_word, av[k] ^ bv[k] ^ 8'h55);
      check(out_ok == pairs_ok(out_word), "R6 flag", W'(out_ok), W'(pairs_ok(out_word)));
      @(negedge clk);
    end
  endtask

  task automatic t_zero();
    for (int d = 0; d < 16; d += 5) begin
      logic [W-1:0] e;
      for (int i = 0; i < DB; i++) begin
        e[2*i+1] = d[i];
        e[2*i]   = d[i];
      end
      drive('0, enc(DB'(d)));
      in_valid = 1'b0;
      check(out_word == e, "R5 zero leak", out_word, e);
      check(out_ok == 1'b0, "R6 flag low", W'(out_ok), '0);
      @(negedge clk);
    end
  endtask

  task automatic t_b2b();
    out_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      drive(enc(DB'(k + 2)), enc(DB'(9)));
      check(out_valid == 1'b1 && out_word == enc(DB'(k + 2) ^ DB'(9)),
            "R9 back to back", out_word, enc(DB'(k + 2) ^ DB'(9)));
      check(in_ready == 1'b1, "R9 ready", W'(in_ready), W'(1));
    end
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R7 drained", W'(out_valid), '0);
  endtask

  task automatic t_stall();
    logic [W-1:0] x, y;
    x = enc(4'd6) ^ 8'h00;
    y = enc(4'd11);
    out_ready = 1'b0;
    drive(x, enc(4'd0));
    check(in_ready == 1'b0, "R8 ready low", W'(in_ready), '0);
    op_a = y;
    op_b = enc(4'd0);
    for (int k = 0; k < 2; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(out_word == x, "R10 held word", out_word, x);
      check(out_valid == 1'b1, "R8 held valid", W'(out_valid), W'(1));
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_word == y, "R8 replace", out_word, y);
    op_a = enc(4'd3);
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R10 idle", W'(out_valid), '0);
    @(posedge clk);
    @(negedge clk);
    check(out_word == y, "R10 idle word", out_word, y);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    @(negedge clk);
    t_layout();
    t_valid_pairs();
    t_raw();
    t_zero();
    t_b2b();
    t_stall();
    finish_run();
  end

endmodule